// File: doc/BRIEF.md
# Saturating Accumulator Datapath

This block is the 32-bit two's-complement accumulator of a small fixed-point DSP core. On each cycle with the execute strobe high it applies one of sixteen operations to the accumulator. The operations combine the accumulator with a 16-bit data operand or a 32-bit product value, and the result is written on the rising clock edge. Instruction decode, memory and the multiplier array sit outside the block. The core hands the block a 4-bit operation code, a 4-bit shift count, the operand and the product register, and reads back the accumulator and two flags.

Arithmetic results either wrap or clamp to the most positive or most negative value, depending on an overflow-mode bit that the block holds itself. A sticky-free overflow flag reports whether the most recent arithmetic operation overflowed. The high-half operations work on bits 31:16 alone. A conditional-subtract step performs one bit of a restoring division per cycle, so sixteen steps leave the remainder in the upper half and the quotient in the lower half.

Top module: `acc_sat_alu`

## Requirements
- R1: A synchronous active-high `rst` clears the accumulator, the overflow flag and the overflow-mode bit at the next rising edge, whatever the other inputs are.
- R2: When `exec` is low, the accumulator, `ovf` and `ovm` keep their values.
- R3: Load (op 0) writes the operand, sign-extended to 32 bits and shifted left by `shamt` (0 to 15), into the accumulator.
- R4: Add (op 1) and subtract (op 2) combine the accumulator with the operand, which is sign-extended and shifted as in R3. `ovf` becomes 1 when the operands have signs that allow overflow and the result sign differs from the accumulator sign, and 0 otherwise. With `ovm` at 0 the result wraps.
- R5: With `ovm` at 1, an overflowing add, subtract or product operation writes 0x7FFFFFFF when the accumulator was non-negative and 0x80000000 when it was negative.
- R6: High add (op 3) and high subtract (op 4) apply the unsigned operand to bits 31:16 only, with 16-bit overflow detection, and leave bits 15:0 unchanged. Under saturation only the upper half is forced, to 0x7FFF or 0x8000.
- R7: Absolute value (op 8) negates a negative accumulator and leaves a non-negative one unchanged. 0x80000000 becomes 0x7FFFFFFF when `ovm` is 1 and stays 0x80000000 when `ovm` is 0.
- R8: Product add (op 9) and product subtract (op 10) add `product` to the accumulator or subtract it, with the flag and saturation rules of R4 and R5.
- R9: The conditional-subtract step (op 11) forms D = ACC − (zero-extended operand << 15). If D is non-negative the accumulator becomes (D << 1) + 1. Otherwise it becomes ACC << 1. Sixteen steps on dividend 10 and divisor 3 give 0x00010003.
- R10: AND (op 5) gives {16'h0, ACC[15:0] & operand}. OR (op 6) and XOR (op 7) change only bits 15:0, and bits 31:16 keep their value.
- R11: Zero-load-high (op 12) writes {operand, 16'h0}. Zero-load-low (op 13) writes {16'h0, operand}.
- R12: Op 14 sets `ovm` and op 15 clears it. Neither changes the accumulator. Ops 0 and 5 to 8 and 11 to 15 leave `ovf` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| exec | input | 1 | Execute strobe; an operation takes effect only when this is high |
| op | input | 4 | Operation code (see requirements) |
| shamt | input | 4 | Left shift applied to the operand for load, add and subtract |
| opnd | input | 16 | Data operand |
| product | input | 32 | Product register value |
| acc | output | 32 | Accumulator (registered) |
| ovf | output | 1 | Overflow flag of the last arithmetic operation (registered) |
| ovm | output | 1 | Overflow-mode bit; 1 selects saturation (registered) |

## Verification
The bench builds the block with its default operand width of 16, which gives a 32-bit accumulator and a 4-bit shift count. With these values it can reach the full shift of 15 and the exact clamp constants 0x7FFFFFFF, 0x80000000, 0x7FFF and 0x8000. A chained vector table walks the accumulator across positive and negative overflow in both modes. It also covers the absolute value of the most negative number and the high-half clamps with a nonzero lower half. Directed runs then cover the hold on a low strobe, reset in the middle of a run, and a full sixteen-step division.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [3:0] {
    OP_LOAD = 4'd0,
    OP_ADD  = 4'd1,
    OP_SUB  = 4'd2,
    OP_ADDH = 4'd3,
    OP_SUBH = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_ABS  = 4'd8,
    OP_PADD = 4'd9,
    OP_PSUB = 4'd10,
    OP_DSTP = 4'd11,
    OP_ZLH  = 4'd12,
    OP_ZLL  = 4'd13,
    OP_SATON  = 4'd14,
    OP_SATOFF = 4'd15
  } acc_op_e;

endpackage

// File: rtl/acc_opnd_shift.sv
// Widens the data operand to accumulator width (sign or zero fill) and shifts left.
module acc_opnd_shift #(
  parameter int DW = 16,
  parameter int AW = 32,
  parameter int SW = 4
) (
  input  logic [DW-1:0] din,
  input  logic [SW-1:0] amt,
  input  logic          sext,
  output logic [AW-1:0] dout
);
  localparam int FILL = AW - DW;

  logic [AW-1:0] wide;

  always_comb begin
    wide = sext ? {{FILL{din[DW-1]}}, din} : {{FILL{1'b0}}, din};
    dout = wide << amt;
  end
endmodule

// File: rtl/acc_addsub_sat.sv
// Two's-complement add/subtract with sign-based overflow detect and optional clamp.
module acc_addsub_sat #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         sat_en,
  output logic [W-1:0] res,
  output logic         ovf
);
  localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] raw;
  logic         sign_ok;

  always_comb begin
    raw     = sub ? (a - b) : (a + b);
    sign_ok = sub ? (a[W-1] != b[W-1]) : (a[W-1] == b[W-1]);
    ovf     = sign_ok && (raw[W-1] != a[W-1]);
    if (ovf && sat_en)
      res = a[W-1] ? NEG_LIM : POS_LIM;
    else
      res = raw;
  end
endmodule

// File: rtl/acc_cond_sub.sv
// One restoring-division step: subtract, then shift in a quotient bit.
module acc_cond_sub #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] acc_in,
  input  logic [AW-1:0] divisor_sh,
  output logic [AW-1:0] acc_out
);
  logic [AW-1:0] diff;

  always_comb begin
    diff = acc_in - divisor_sh;
    if (diff[AW-1])
      acc_out = {acc_in[AW-2:0], 1'b0};
    else
      acc_out = {diff[AW-2:0], 1'b1};
  end
endmodule

// File: rtl/acc_sat_alu.sv
module acc_sat_alu
  import acc_alu_pkg::*;
#(
  parameter  int DATA_W  = 16,
  localparam int ACC_W   = 2 * DATA_W,
  localparam int SHIFT_W = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               exec,
  input  logic [3:0]         op,
  input  logic [SHIFT_W-1:0] shamt,
  input  logic [DATA_W-1:0]  opnd,
  input  logic [ACC_W-1:0]   product,
  output logic [ACC_W-1:0]   acc,
  output logic               ovf,
  output logic               ovm
);
  localparam logic [ACC_W-1:0]   ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0]   ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic [SHIFT_W-1:0] DIV_SH  = SHIFT_W'(DATA_W - 1);

  acc_op_e op_e;
  assign op_e = acc_op_e'(op);

  // Operand paths: shifted signed operand, and zero-filled divisor at fixed shift
  logic [ACC_W-1:0] opnd_sh;
  logic [ACC_W-1:0] div_sh;

  acc_opnd_shift #(.DW(DATA_W), .AW(ACC_W), .SW(SHIFT_W)) u_shift_main (
    .din(opnd), .amt(shamt), .sext(1'b1), .dout(opnd_sh)
  );

  acc_opnd_shift #(.DW(DATA_W), .AW(ACC_W), .SW(SHIFT_W)) u_shift_div (
    .din(opnd), .amt(DIV_SH), .sext(1'b0), .dout(div_sh)
  );

  // Full-width arithmetic unit
  logic             use_prod;
  logic             full_sub;
  logic [ACC_W-1:0] full_b;
  logic [ACC_W-1:0] full_res;
  logic             full_ovf;

  assign use_prod = (op_e == OP_PADD) || (op_e == OP_PSUB);
  assign full_sub = (op_e == OP_SUB) || (op_e == OP_PSUB);
  assign full_b   = use_prod ? product : opnd_sh;

  acc_addsub_sat #(.W(ACC_W)) u_full (
    .a(acc), .b(full_b), .sub(full_sub), .sat_en(ovm),
    .res(full_res), .ovf(full_ovf)
  );

  // Upper-half arithmetic unit
  logic [DATA_W-1:0] hi_res;
  logic              hi_ovf;

  acc_addsub_sat #(.W(DATA_W)) u_high (
    .a(acc[ACC_W-1:DATA_W]), .b(opnd), .sub(op_e == OP_SUBH), .sat_en(ovm),
    .res(hi_res), .ovf(hi_ovf)
  );

  // Division step
  logic [ACC_W-1:0] div_res;

  acc_cond_sub #(.AW(ACC_W)) u_div (
    .acc_in(acc), .divisor_sh(div_sh), .acc_out(div_res)
  );

  // Absolute value
  logic [ACC_W-1:0] neg_acc;
  logic [ACC_W-1:0] abs_res;

  always_comb begin
    neg_acc = -acc;
    if (!acc[ACC_W-1])
      abs_res = acc;
    else if (ovm && (neg_acc == ACC_MIN))
      abs_res = ACC_MAX;
    else
      abs_res = neg_acc;
  end

  // Next-state selection
  logic [ACC_W-1:0] acc_nxt;
  logic             ovf_nxt;
  logic             ovm_nxt;

  always_comb begin
    acc_nxt = acc;
    ovf_nxt = ovf;
    ovm_nxt = ovm;
    unique case (op_e)
      OP_LOAD: acc_nxt = opnd_sh;
      OP_ADD, OP_SUB, OP_PADD, OP_PSUB: begin
        acc_nxt = full_res;
        ovf_nxt = full_ovf;
      end
      OP_ADDH, OP_SUBH: begin
        acc_nxt = {hi_res, acc[DATA_W-1:0]};
        ovf_nxt = hi_ovf;
      end
      OP_AND:  acc_nxt = {{DATA_W{1'b0}}, acc[DATA_W-1:0] & opnd};
      OP_OR:   acc_nxt = {acc[ACC_W-1:DATA_W], acc[DATA_W-1:0] | opnd};
      OP_XOR:  acc_nxt = {acc[ACC_W-1:DATA_W], acc[DATA_W-1:0] ^ opnd};
      OP_ABS:  acc_nxt = abs_res;
      OP_DSTP: acc_nxt = div_res;
      OP_ZLH:  acc_nxt = {opnd, {DATA_W{1'b0}}};
      OP_ZLL:  acc_nxt = {{DATA_W{1'b0}}, opnd};
      OP_SATON:  ovm_nxt = 1'b1;
      OP_SATOFF: ovm_nxt = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      ovf <= 1'b0;
      ovm <= 1'b0;
    end else if (exec) begin
      acc <= acc_nxt;
      ovf <= ovf_nxt;
      ovm <= ovm_nxt;
    end
  end
endmodule

// File: rtl/acc_sat_alu_chk.sv
module acc_sat_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             exec,
  input logic [3:0]       op,
  input logic [ACC_W-1:0] acc,
  input logic             ovf,
  input logic             ovm
);
  localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic flag_neutral;
  assign flag_neutral = (op == OP_LOAD) || (op == OP_AND) || (op == OP_OR) ||
                        (op == OP_XOR) || (op == OP_ABS) || (op == OP_DSTP) ||
                        (op == OP_ZLH) || (op == OP_ZLL) || (op == OP_SATON) ||
                        (op == OP_SATOFF);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (acc == '0) && !ovf && !ovm);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !exec |=> $stable(acc) && $stable(ovf) && $stable(ovm));

  // R5
  full_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    exec && ovm && ((op == OP_ADD) || (op == OP_SUB) || (op == OP_PADD) || (op == OP_PSUB))
    |=> !ovf || (acc == ACC_MAX) || (acc == ACC_MIN));

  // R6
  high_low_keep_chk: assert property (@(posedge clk) disable iff (rst)
    exec && ((op == OP_ADDH) || (op == OP_SUBH))
    |=> acc[DATA_W-1:0] == $past(acc[DATA_W-1:0]));

  // R10
  and_upper_clear_chk: assert property (@(posedge clk) disable iff (rst)
    exec && (op == OP_AND) |=> acc[ACC_W-1:DATA_W] == '0);

  // R10
  xor_upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
    exec && ((op == OP_XOR) || (op == OP_OR))
    |=> acc[ACC_W-1:DATA_W] == $past(acc[ACC_W-1:DATA_W]));

  // R11
  zlh_low_clear_chk: assert property (@(posedge clk) disable iff (rst)
    exec && (op == OP_ZLH) |=> acc[DATA_W-1:0] == '0);

  // R12
  flag_keep_chk: assert property (@(posedge clk) disable iff (rst)
    exec && flag_neutral |=> $stable(ovf));

  // R12
  mode_set_chk: assert property (@(posedge clk) disable iff (rst)
    exec && (op == OP_SATON) |=> ovm && $stable(acc));
endmodule

bind acc_sat_alu acc_sat_alu_chk #(.DATA_W(DATA_W), .ACC_W(ACC_W)) i_chk (
  .clk(clk), .rst(rst), .exec(exec), .op(op), .acc(acc), .ovf(ovf), .ovm(ovm)
);

// File: tb/test_acc_sat_alu.sv
module test_acc_sat_alu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        exec = 1'b0;
  logic [3:0]  op = 4'd0;
  logic [3:0]  shamt = 4'd0;
  logic [15:0] opnd = 16'h0;
  logic [31:0] product = 32'h0;
  logic [31:0] acc;
  logic        ovf;
  logic        ovm;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  acc_sat_alu i_acc_sat_alu (
    .clk(clk), .rst(rst), .exec(exec), .op(op), .shamt(shamt),
    .opnd(opnd), .product(product), .acc(acc), .ovf(ovf), .ovm(ovm)
  );

  // {op, shamt, opnd, product, exp_acc, exp_ovf, exp_ovm, req}; chained from reset state
  localparam int NV = 45;
  localparam logic [93:0] VEC [NV] = '{
    {4'd0,  4'd4,  16'h8001, 32'h0,        32'hFFF80010, 1'b0, 1'b0, 4'd3},  // R3
    {4'd0,  4'd0,  16'h1234, 32'h0,        32'h00001234, 1'b0, 1'b0, 4'd3},  // R3
    {4'd0,  4'd15, 16'h0001, 32'h0,        32'h00008000, 1'b0, 1'b0, 4'd3},  // R3
    {4'd1,  4'd15, 16'h7FFF, 32'h0,        32'h40000000, 1'b0, 1'b0, 4'd4},  // R4
    {4'd1,  4'd15, 16'h7FFF, 32'h0,        32'h7FFF8000, 1'b0, 1'b0, 4'd4},  // R4
    {4'd1,  4'd0,  16'h8000, 32'h0,        32'h7FFF0000, 1'b0, 1'b0, 4'd4},  // R4
    {4'd1,  4'd15, 16'h4000, 32'h0,        32'h9FFF0000, 1'b1, 1'b0, 4'd4},  // R4 wrap
    {4'd2,  4'd0,  16'h0001, 32'h0,        32'h9FFEFFFF, 1'b0, 1'b0, 4'd4},  // R4
    {4'd14, 4'd0,  16'h0000, 32'h0,        32'h9FFEFFFF, 1'b0, 1'b1, 4'd12}, // R12
    {4'd2,  4'd15, 16'h7FFF, 32'h0,        32'h80000000, 1'b1, 1'b1, 4'd5},  // R5
    {4'd1,  4'd0,  16'hFFFF, 32'h0,        32'h80000000, 1'b1, 1'b1, 4'd5},  // R5
    {4'd8,  4'd0,  16'h0000, 32'h0,        32'h7FFFFFFF, 1'b1, 1'b1, 4'd7},  // R7
    {4'd1,  4'd0,  16'h0001, 32'h0,        32'h7FFFFFFF, 1'b1, 1'b1, 4'd5},  // R5
    {4'd15, 4'd0,  16'h0000, 32'h0,        32'h7FFFFFFF, 1'b1, 1'b0, 4'd12}, // R12
    {4'd2,  4'd0,  16'h0001, 32'h0,        32'h7FFFFFFE, 1'b0, 1'b0, 4'd4},  // R4
    {4'd8,  4'd0,  16'h0000, 32'h0,        32'h7FFFFFFE, 1'b0, 1'b0, 4'd7},  // R7
    {4'd12, 4'd0,  16'h8000, 32'h0,        32'h80000000, 1'b0, 1'b0, 4'd11}, // R11
    {4'd8,  4'd0,  16'h0000, 32'h0,        32'h80000000, 1'b0, 1'b0, 4'd7},  // R7
    {4'd0,  4'd0,  16'hFFFD, 32'h0,        32'hFFFFFFFD, 1'b0, 1'b0, 4'd3},  // R3
    {4'd8,  4'd0,  16'h0000, 32'h0,        32'h00000003, 1'b0, 1'b0, 4'd7},  // R7
    {4'd13, 4'd0,  16'hFFFF, 32'h0,        32'h0000FFFF, 1'b0, 1'b0, 4'd11}, // R11
    {4'd3,  4'd0,  16'h7FFF, 32'h0,        32'h7FFFFFFF, 1'b0, 1'b0, 4'd6},  // R6
    {4'd3,  4'd0,  16'h0001, 32'h0,        32'h8000FFFF, 1'b1, 1'b0, 4'd6},  // R6 wrap
    {4'd14, 4'd0,  16'h0000, 32'h0,        32'h8000FFFF, 1'b1, 1'b1, 4'd12}, // R12
    {4'd4,  4'd0,  16'h0001, 32'h0,        32'h8000FFFF, 1'b1, 1'b1, 4'd6},  // R6 clamp
    {4'd4,  4'd0,  16'h8000, 32'h0,        32'h0000FFFF, 1'b0, 1'b1, 4'd6},  // R6
    {4'd13, 4'd0,  16'h1234, 32'h0,        32'h00001234, 1'b0, 1'b1, 4'd11}, // R11
    {4'd3,  4'd0,  16'h7FFF, 32'h0,        32'h7FFF1234, 1'b0, 1'b1, 4'd6},  // R6
    {4'd3,  4'd0,  16'h0002, 32'h0,        32'h7FFF1234, 1'b1, 1'b1, 4'd6},  // R6 clamp
    {4'd9,  4'd0,  16'h0000, 32'h00010000, 32'h7FFFFFFF, 1'b1, 1'b1, 4'd8},  // R8
    {4'd10, 4'd0,  16'h0000, 32'h7FFFFFFF, 32'h00000000, 1'b0, 1'b1, 4'd8},  // R8
    {4'd10, 4'd0,  16'h0000, 32'h80000000, 32'h7FFFFFFF, 1'b1, 1'b1, 4'd8},  // R8
    {4'd9,  4'd0,  16'h0000, 32'hFFFFFFFF, 32'h7FFFFFFE, 1'b0, 1'b1, 4'd8},  // R8
    {4'd15, 4'd0,  16'h0000, 32'h0,        32'h7FFFFFFE, 1'b0, 1'b0, 4'd12}, // R12
    {4'd9,  4'd0,  16'h0000, 32'h00000002, 32'h80000000, 1'b1, 1'b0, 4'd8},  // R8 wrap
    {4'd0,  4'd0,  16'hABCD, 32'h0,        32'hFFFFABCD, 1'b1, 1'b0, 4'd12}, // R12
    {4'd5,  4'd0,  16'h0FF0, 32'h0,        32'h00000BC0, 1'b1, 1'b0, 4'd10}, // R10
    {4'd0,  4'd4,  16'h1234, 32'h0,        32'h00012340, 1'b1, 1'b0, 4'd3},  // R3
    {4'd6,  4'd0,  16'h000F, 32'h0,        32'h0001234F, 1'b1, 1'b0, 4'd10}, // R10
    {4'd7,  4'd0,  16'hFFFF, 32'h0,        32'h0001DCB0, 1'b1, 1'b0, 4'd10}, // R10
    {4'd0,  4'd15, 16'h0003, 32'h0,        32'h00018000, 1'b1, 1'b0, 4'd3},  // R3
    {4'd11, 4'd0,  16'h0003, 32'h0,        32'h00000001, 1'b1, 1'b0, 4'd9},  // R9
    {4'd11, 4'd0,  16'h0003, 32'h0,        32'h00000002, 1'b1, 1'b0, 4'd9},  // R9
    {4'd12, 4'd0,  16'h1234, 32'h0,        32'h12340000, 1'b1, 1'b0, 4'd11}, // R11
    {4'd10, 4'd0,  16'h0000, 32'h12340001, 32'hFFFFFFFF, 1'b0, 1'b0, 4'd8}   // R8
  };

  task automatic check(input string req, input logic [31:0] e_acc,
                       input logic e_ovf, input logic e_ovm);
    total++;
    if (acc !== e_acc || ovf !== e_ovf || ovm !== e_ovm) begin
      bad++;
      $display("FAIL %s: acc=%08h ovf=%0b ovm=%0b expected acc=%08h ovf=%0b ovm=%0b",
               req, acc, ovf, ovm, e_acc, e_ovf, e_ovm);
    end
  endtask

  task automatic run_op(input logic [3:0] o, input logic [3:0] s,
                        input logic [15:0] d, input logic [31:0] p, input logic en);
    @(negedge clk);
    op = o; shamt = s; opnd = d; product = p; exec = en;
    @(negedge clk);
    exec = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1", 32'h0, 1'b0, 1'b0);  // reset state

    for (int i = 0; i < NV; i++) begin
      logic [93:0] e;
      e = VEC[i];
      run_op(e[93:90], e[89:86], e[85:70], e[69:38], 1'b1);
      check($sformatf("R%0d vec%0d", e[3:0], i), e[37:6], e[5], e[4]);
    end

    // R2: strobe low, add that would change everything has no effect
    run_op(4'd14, 4'd0, 16'h0, 32'h0, 1'b0);
    run_op(4'd1, 4'd15, 16'h7FFF, 32'h0, 1'b0);
    check("R2", 32'hFFFFFFFF, 1'b0, 1'b0);

    // R1: reset mid-run with a live strobe
    run_op(4'd14, 4'd0, 16'h0, 32'h0, 1'b1);
    run_op(4'd1, 4'd0, 16'h4000, 32'h0, 1'b1);
    @(negedge clk);
    rst = 1'b1; exec = 1'b1; op = 4'd1; opnd = 16'h1111;
    @(negedge clk);
    rst = 1'b0; exec = 1'b0;
    check("R1", 32'h0, 1'b0, 1'b0);

    // R9: full sixteen-step division 10 / 3 -> remainder 1, quotient 3
    run_op(4'd13, 4'd0, 16'd10, 32'h0, 1'b1);
    for (int k = 0; k < 16; k++) run_op(4'd11, 4'd0, 16'd3, 32'h0, 1'b1);
    check("R9", 32'h00010003, 1'b0, 1'b0);

    // R5: negative clamp on subtract with mode on
    run_op(4'd14, 4'd0, 16'h0, 32'h0, 1'b1);
    run_op(4'd12, 4'd0, 16'h8000, 32'h0, 1'b1);
    run_op(4'd2, 4'd0, 16'h0001, 32'h0, 1'b1);
    check("R5", 32'h80000000, 1'b1, 1'b1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule